// File: doc/BRIEF.md
# Interval Timer with Compare Interrupt

This block is a per-processor interval timer. A free-running cycle counter advances by one on every clock. A 32-bit compare register holds the cycle at which the next interrupt is due. Both registers sit behind a single register address, and the access direction picks between them. A read at that address returns the counter at its full width. A write at that address loads the compare value. Whenever the low 32 bits of the counter equal the compare value, the block records a pending interrupt. It drives that interrupt out unless the mask input suppresses it.

Software keeps a periodic tick by reading the counter, adding its period and writing the sum back as the next compare value. If software writes a value the counter has already passed, no interrupt arrives until the low 32 bits of the counter come round to it again. The pending flag stays set until software either writes a new compare value or pulses the acknowledge input. A match that happens while the interrupt is masked is therefore kept, not lost.

Top module: `itmr_top`

## Requirements
- R1: After reset the counter is zero, the compare register is all ones, the pending flag is clear, `irqOut` is low and `regRdData` is zero.
- R2: While out of reset the counter increases by exactly one on every clock edge, wrapping modulo 2^CNT_W.
- R3: A read (`regRdEn` high) at the timer address loads `regRdData`, one edge later, with the counter value held before that edge, at full width. A read at any other address loads zero. With `regRdEn` low, `regRdData` holds its value.
- R4: A write (`regWrEn` high) at the timer address loads the compare register from `regWrData`. A write at any other address leaves the compare register unchanged.
- R5: The pending flag sets on the edge at which the counter's low 32 bits equal the compare register. Counter bits above bit 31 take no part in the test.
- R6: Once set, the pending flag stays set until it is cleared. A write to the compare register clears it, and this clear takes priority over a match on the same edge.
- R7: A high `irqAck` clears the pending flag. A match on the same edge takes priority, so the flag stays set.
- R8: `irqOut` equals the pending flag while `irqMask` is low and is held low while `irqMask` is high. A match that occurs while masked is still recorded and appears on `irqOut` once the mask drops.
- R9: A compare value below the current counter's low 32 bits raises no interrupt until those bits wrap round to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on each rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register address of the access |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data (new compare value) |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | CNT_W | Read data, registered |
| irqMask | input | 1 | High suppresses `irqOut` |
| irqAck | input | 1 | Clears the pending flag |
| irqOut | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are the same-edge collisions: an acknowledge, or a compare write, landing on the exact edge where the counter matches. The bench tracks the counter in its own model. It waits for the falling edge at which the model counter equals the programmed compare value, then drives the acknowledge or the write, so that the strobe and the match share one rising edge. A compare value set just behind the counter is then held for several hundred cycles to show that no interrupt appears before the 32-bit wrap.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  // Width of the compare register and of the equality test.
  localparam int CMP_W = 32;

  // Strobes from control to datapath, one set per cycle.
  typedef struct packed {
    logic ldCmp;   // load compare register from write data
    logic rdCnt;   // capture counter into read data
    logic rdZero;  // read at a foreign address: return zero
  } itmr_strb_t;

endpackage

// File: rtl/itmr_dp.sv
module itmr_dp
  import itmr_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  itmr_strb_t       strb,
  input  logic [CMP_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  output logic             cntMatch
);

  localparam logic [CMP_W-1:0] CMP_RST = '1;

  logic [CNT_W-1:0] cntQ;
  logic [CMP_W-1:0] cmpQ;
  logic [CNT_W-1:0] rdQ;
  logic [CMP_W-1:0] cntLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntQ <= '0;
    else       cntQ <= cntQ + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cmpQ <= CMP_RST;
    else if (strb.ldCmp) cmpQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdQ <= '0;
    else if (strb.rdCnt)  rdQ <= cntQ;
    else if (strb.rdZero) rdQ <= '0;
  end

  // Only the low bits of a wide counter take part in the equality test.
  generate
    if (CNT_W == CMP_W) begin : g_narrow
      assign cntLow = cntQ;
    end else begin : g_wide
      assign cntLow = cntQ[CMP_W-1:0];
    end
  endgenerate

  assign cntMatch = (cntLow == cmpQ);
  assign rdData   = rdQ;

  // Checks
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> cntQ == CNT_W'($past(cntQ) + CNT_W'(1)));

  assert_cmp_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldCmp |=> cmpQ == $past(wrData));

  assert_cmp_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ldCmp |=> $stable(cmpQ));

  assert_rd_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdCnt |=> rdData == $past(cntQ));

endmodule

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
  import itmr_pkg::*;
#(
  parameter int          ADDR_W     = 4,
  parameter int unsigned TIMER_ADDR = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              irqAck,
  input  logic              irqMask,
  input  logic              cntMatch,
  output itmr_strb_t        strb,
  output logic              irqOut
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(TIMER_ADDR);

  logic addrHit;
  logic pendQ;
  logic pendD;

  assign addrHit     = (regAddr == HIT_ADDR);
  assign strb.ldCmp  = regWrEn & addrHit;
  assign strb.rdCnt  = regRdEn & addrHit;
  assign strb.rdZero = regRdEn & ~addrHit;

  // A compare write supersedes everything; a match beats an acknowledge.
  always_comb begin
    if (strb.ldCmp) pendD = 1'b0;
    else            pendD = cntMatch | (pendQ & ~irqAck);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= pendD;
  end

  assign irqOut = pendQ & ~irqMask;

  // Checks
  assert_match_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cntMatch && !strb.ldCmp) |=> pendQ);

  assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldCmp |=> !pendQ);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !irqAck && !strb.ldCmp) |=> pendQ);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !cntMatch) |=> !pendQ);

  assert_mask_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqMask |-> !irqOut);

endmodule

// File: rtl/itmr_top.sv
module itmr_top
  import itmr_pkg::*;
#(
  parameter int          CNT_W      = 64,
  parameter int          ADDR_W     = 4,
  parameter int unsigned TIMER_ADDR = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  input  logic              regRdEn,
  output logic [CNT_W-1:0]  regRdData,
  input  logic              irqMask,
  input  logic              irqAck,
  output logic              irqOut
);

  itmr_strb_t strb;
  logic       cntMatch;

  itmr_ctrl #(
    .ADDR_W    (ADDR_W),
    .TIMER_ADDR(TIMER_ADDR)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .irqAck  (irqAck),
    .irqMask (irqMask),
    .cntMatch(cntMatch),
    .strb    (strb),
    .irqOut  (irqOut)
  );

  itmr_dp #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .cntMatch(cntMatch)
  );

endmodule

// File: tb/tb_itmr_top.sv
module tb_itmr_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 64;
  localparam int ADDR_W     = 4;
  localparam logic [ADDR_W-1:0] TADDR = 4'h9;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic              regWrEn = 1'b0;
  logic [31:0]       regWrData = '0;
  logic              regRdEn = 1'b0;
  logic [CNT_W-1:0]  regRdData;
  logic              irqMask = 1'b0;
  logic              irqAck = 1'b0;
  logic              irqOut;

  itmr_top #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .TIMER_ADDR(9)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .irqMask(irqMask), .irqAck(irqAck), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [CNT_W-1:0] mCnt = '0;
  logic [31:0]      mCmp = '1;
  logic             mPend = 1'b0;
  logic [CNT_W-1:0] mRd = '0;
  int    nCmp = 0;
  int    nBad = 0;
  bit    active = 0;
  bit    done = 0;
  string tag = "R1";

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = '0; mCmp = '1; mPend = 1'b0; mRd = '0;
    end else begin
      logic hit, match;
      hit   = (regAddr == TADDR);
      match = (mCnt[31:0] == mCmp);
      if (regRdEn) mRd = hit ? mCnt : '0;
      if (regWrEn && hit) begin
        mPend = 1'b0;
        mCmp  = regWrData;
      end else begin
        mPend = match | (mPend & ~irqAck);
      end
      mCnt = mCnt + 1;
    end
  end

  task automatic check(string req, string what, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (active) begin
        check(tag, "regRdData", regRdData, mRd);
        check(tag, "irqOut", {63'b0, irqOut}, {63'b0, mPend & ~irqMask});
      end
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    cyc(1);
    regWrEn = 1'b0;
  endtask

  task automatic waitMatch(logic [31:0] c);
    for (int i = 0; i < 1000 && mCnt[31:0] != c; i++) cyc(1);
  endtask

  initial begin
    logic [31:0] c;
    // R1: reset values
    repeat (2) @(negedge clk);
    active = 1;
    cyc(2);
    rstN = 1'b1;
    cyc(1);
    // R2: counter steps by one, observed through back-to-back reads
    tag = "R2";
    regAddr = TADDR; regRdEn = 1'b1;
    cyc(8);
    // R3: foreign-address read returns zero, then the value holds
    tag = "R3";
    regAddr = 4'h3;
    cyc(1);
    regRdEn = 1'b0; regAddr = TADDR;
    cyc(1);
    regRdEn = 1'b1; cyc(1); regRdEn = 1'b0;
    cyc(4);
    // R5: match raises pending
    tag = "R5";
    wr(TADDR, mCnt[31:0] + 12);
    cyc(20);
    // R6: sticky, then cleared by compare write
    tag = "R6";
    cyc(10);
    wr(TADDR, mCnt[31:0] + 1000);
    cyc(3);
    // R8: masked match is recorded and shows after unmask
    tag = "R8";
    wr(TADDR, mCnt[31:0] + 8);
    irqMask = 1'b1;
    cyc(15);
    irqMask = 1'b0;
    cyc(3);
    // R7: acknowledge clears
    tag = "R7";
    irqAck = 1'b1; cyc(1); irqAck = 1'b0;
    cyc(3);
    // R4: write at a foreign address leaves the compare untouched
    tag = "R4";
    wr(TADDR, mCnt[31:0] + 40);
    wr(4'h2, mCnt[31:0] + 10);
    cyc(50);
    irqAck = 1'b1; cyc(1); irqAck = 1'b0;
    // R7: acknowledge on the match edge loses to the match
    tag = "R7";
    c = mCnt[31:0] + 10;
    wr(TADDR, c);
    waitMatch(c);
    irqAck = 1'b1; cyc(1); irqAck = 1'b0;
    cyc(3);
    // R6: compare write on the match edge wins over the match
    tag = "R6";
    c = mCnt[31:0] + 10;
    wr(TADDR, c);
    waitMatch(c);
    wr(TADDR, mCnt[31:0] + 5000);
    cyc(5);
    // R9: compare already behind the counter stays silent
    tag = "R9";
    wr(TADDR, mCnt[31:0] - 5);
    cyc(600);
    // R3: read alongside a write in the same cycle
    tag = "R3";
    regRdEn = 1'b1;
    wr(TADDR, mCnt[31:0] + 3);
    regRdEn = 1'b0;
    cyc(8);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule